// File: doc/BRIEF.md
# Single-Precision Floating-Point Comparator

This block orders two IEEE-754 single-precision operands and reports the outcome as a two-bit condition code. A one-cycle start strobe launches a compare. One clock later a done strobe marks valid results: the condition code, an invalid-operation flag, and an updated copy of the caller's status word with the code placed in a fixed field.

There are two compare flavours, chosen per operation by a select input. The quiet flavour treats an unordered result as an error only when a signalling NaN takes part. The signalling flavour treats every unordered result as an error. When the invalid trap is enabled and the compare raises invalid, nothing is committed: the condition-code register holds and the status field passes through untouched.

Top module: `fp_cmp_unit`

## Requirements
- R1: For non-NaN operands the code is 0 for equal, 1 when opa is below opb, and 2 when opa is above opb. The order is numeric: opposite signs are decided by the sign, and for two negative operands the larger magnitude is the smaller value.
- R2: +0 and -0 compare equal to each other. Denormal operands are ordered by magnitude like normal ones, and infinities order beyond every finite value.
- R3: An operand is a NaN when its 8-bit exponent is all ones and its 23-bit fraction is nonzero. If either operand is a NaN the code is 3 (unordered).
- R4: With signal_i = 1, an unordered result sets inv_o.
- R5: With signal_i = 0, an unordered result sets inv_o only if an operand is a signalling NaN, that is a NaN with fraction bit 22 equal to 0.
- R6: An ordered result never sets inv_o.
- R7: done_o is high in exactly the cycle after each cycle in which start_i is sampled high. cc_o, inv_o and stat_o carry that operation's result from that cycle on.
- R8: On a committed compare, stat_o equals stat_i sampled with start_i, except that bits 11:10 hold the new code.
- R9: When trap_en_i = 1 and the compare raises invalid, cc_o keeps its previous value and stat_o bits 11:10 equal stat_i bits 11:10. The other stat_o bits still follow R8.
- R10: After reset, done_o, cc_o, inv_o and stat_o are all zero.
- R11: In a cycle after start_i was sampled low, done_o is low and cc_o, inv_o and stat_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch a compare this cycle |
| signal_i | input | 1 | 1 selects the signalling compare, 0 the quiet compare |
| trap_en_i | input | 1 | Invalid trap enable; blocks commit on invalid |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| stat_i | input | 32 | Current status word to be updated |
| done_o | output | 1 | One-cycle result strobe |
| cc_o | output | 2 | Condition code register |
| inv_o | output | 1 | Invalid flag of the last compare |
| stat_o | output | 32 | Updated status word |

## Verification
The bench targets the places where a comparator usually breaks. It compares +0 with -0; a design that compares raw bits would report them unequal. It compares pairs of negative numbers, where a design that forgets to reverse the magnitude order would swap codes 1 and 2. It also checks denormals against zero and infinities against the largest finite values.

The bench drives NaNs whose fraction has only bit 22 set, only low bits set, or is zero. Treating infinity as a NaN, or testing the wrong quiet bit, shows up as a wrong code or a wrong invalid flag. Trapped invalid compares follow an ordered one, so a design that commits the code under a trap is exposed because its held code changes.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  typedef enum logic [1:0] {
    CC_EQ = 2'd0,
    CC_LT = 2'd1,
    CC_GT = 2'd2,
    CC_UN = 2'd3
  } cc_e;

  typedef struct packed {
    logic sign;
    logic zero;
    logic nan;
    logic snan;
  } opcls_t;

endpackage

// File: rtl/fpc_rst_sync.sv
module fpc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/fpc_classify.sv
module fpc_classify
  import fpc_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] op_i,
  output opcls_t               cls_o
);
  localparam int W = 1 + EXP_W + MAN_W;

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] frac_f;
  logic             exp_max;
  logic             frac_nz;

  assign exp_f   = op_i[W-2 -: EXP_W];
  assign frac_f  = op_i[MAN_W-1:0];
  assign exp_max = &exp_f;
  assign frac_nz = |frac_f;

  always_comb begin
    cls_o.sign = op_i[W-1];
    cls_o.zero = (exp_f == '0) && !frac_nz;
    cls_o.nan  = exp_max && frac_nz;
    // quiet bit is the top fraction bit; clear means signalling
    cls_o.snan = exp_max && frac_nz && !frac_f[MAN_W-1];
  end
endmodule

// File: rtl/fpc_order.sv
module fpc_order
  import fpc_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] opa_i,
  input  logic [EXP_W+MAN_W:0] opb_i,
  input  opcls_t               cls_a_i,
  input  opcls_t               cls_b_i,
  input  logic                 signal_i,
  output cc_e                  cc_o,
  output logic                 inv_o
);
  localparam int W = 1 + EXP_W + MAN_W;

  logic [W-2:0] mag_a, mag_b;
  logic         a_mag_small;
  logic         mag_same;

  assign mag_a       = opa_i[W-2:0];
  assign mag_b       = opb_i[W-2:0];
  assign a_mag_small = mag_a < mag_b;
  assign mag_same    = mag_a == mag_b;

  always_comb begin
    if (cls_a_i.nan || cls_b_i.nan) begin
      cc_o = CC_UN;
    end else if (cls_a_i.zero && cls_b_i.zero) begin
      cc_o = CC_EQ;
    end else if (cls_a_i.sign != cls_b_i.sign) begin
      cc_o = cls_a_i.sign ? CC_LT : CC_GT;
    end else if (mag_same) begin
      cc_o = CC_EQ;
    end else if (a_mag_small ^ cls_a_i.sign) begin
      cc_o = CC_LT;
    end else begin
      cc_o = CC_GT;
    end
  end

  always_comb begin
    inv_o = 1'b0;
    if (cc_o == CC_UN) begin
      inv_o = signal_i || cls_a_i.snan || cls_b_i.snan;
    end
  end
endmodule

// File: rtl/fpc_commit.sv
module fpc_commit
  import fpc_pkg::*;
#(
  parameter int STAT_W = 32,
  parameter int CC_LSB = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              trap_en_i,
  input  cc_e               cc_i,
  input  logic              inv_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic              done_o,
  output logic [1:0]        cc_o,
  output logic              inv_o,
  output logic [STAT_W-1:0] stat_o
);
  localparam logic [STAT_W-1:0] CC_MASK = STAT_W'(3) << CC_LSB;

  logic              done_d, done_q;
  logic [1:0]        cc_d, cc_q;
  logic              inv_d, inv_q;
  logic [STAT_W-1:0] stat_d, stat_q;
  logic              load_en;
  logic              blocked;
  logic [STAT_W-1:0] stat_ins;

  assign load_en  = start_i;
  assign blocked  = inv_i && trap_en_i;
  assign stat_ins = (stat_i & ~CC_MASK) | (STAT_W'(cc_i) << CC_LSB);

  always_comb begin
    done_d = load_en;
    cc_d   = cc_q;
    inv_d  = inv_q;
    stat_d = stat_q;
    if (load_en) begin
      inv_d = inv_i;
      if (blocked) begin
        stat_d = stat_i;
      end else begin
        cc_d   = cc_i;
        stat_d = stat_ins;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      cc_q   <= 2'd0;
      inv_q  <= 1'b0;
      stat_q <= '0;
    end else begin
      done_q <= done_d;
      cc_q   <= cc_d;
      inv_q  <= inv_d;
      stat_q <= stat_d;
    end
  end

  assign done_o = done_q;
  assign cc_o   = cc_q;
  assign inv_o  = inv_q;
  assign stat_o = stat_q;
endmodule

// File: rtl/fp_cmp_unit.sv
module fp_cmp_unit
  import fpc_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int MAN_W  = 23,
  parameter int STAT_W = 32,
  parameter int CC_LSB = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 signal_i,
  input  logic                 trap_en_i,
  input  logic [EXP_W+MAN_W:0] opa_i,
  input  logic [EXP_W+MAN_W:0] opb_i,
  input  logic [STAT_W-1:0]    stat_i,
  output logic                 done_o,
  output logic [1:0]           cc_o,
  output logic                 inv_o,
  output logic [STAT_W-1:0]    stat_o
);
  localparam int W = 1 + EXP_W + MAN_W;

  logic   rst_sync_n;
  opcls_t cls [2];
  cc_e    cc_w;
  logic   inv_w;

  fpc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fpc_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .op_i  ((g == 0) ? opa_i : opb_i),
      .cls_o (cls[g])
    );
  end

  fpc_order #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_ord (
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .cls_a_i  (cls[0]),
    .cls_b_i  (cls[1]),
    .signal_i (signal_i),
    .cc_o     (cc_w),
    .inv_o    (inv_w)
  );

  fpc_commit #(.STAT_W(STAT_W), .CC_LSB(CC_LSB)) u_cmt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start_i   (start_i),
    .trap_en_i (trap_en_i),
    .cc_i      (cc_w),
    .inv_i     (inv_w),
    .stat_i    (stat_i),
    .done_o    (done_o),
    .cc_o      (cc_o),
    .inv_o     (inv_o),
    .stat_o    (stat_o)
  );
endmodule

// File: rtl/fp_cmp_unit_chk.sv
module fp_cmp_unit_chk #(
  parameter int EXP_W  = 8,
  parameter int MAN_W  = 23,
  parameter int STAT_W = 32,
  parameter int CC_LSB = 10
) (
  input logic                 clk,
  input logic                 rst_sync_n,
  input logic                 start_i,
  input logic                 signal_i,
  input logic                 trap_en_i,
  input logic [EXP_W+MAN_W:0] opa_i,
  input logic [EXP_W+MAN_W:0] opb_i,
  input logic [STAT_W-1:0]    stat_i,
  input logic                 done_o,
  input logic [1:0]           cc_o,
  input logic                 inv_o,
  input logic [STAT_W-1:0]    stat_o
);
  localparam int W = 1 + EXP_W + MAN_W;
  localparam logic [STAT_W-1:0] KEEP = ~(STAT_W'(3) << CC_LSB);

  logic a_nan, b_nan;
  assign a_nan = (&opa_i[W-2 -: EXP_W]) && (|opa_i[MAN_W-1:0]);
  assign b_nan = (&opb_i[W-2 -: EXP_W]) && (|opb_i[MAN_W-1:0]);

  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start_i |=> done_o); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !start_i |=> !done_o && $stable(cc_o) && $stable(inv_o) && $stable(stat_o)); // R11

  AST_SAME_BITS_EQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start_i && (opa_i == opb_i) && !a_nan |=> (cc_o == 2'd0) && !inv_o); // R1

  AST_NAN_SIG_INV: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start_i && signal_i && (a_nan || b_nan) |=> inv_o); // R4

  AST_ORDERED_NO_INV: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start_i && !a_nan && !b_nan |=> !inv_o); // R6

  AST_TRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start_i && trap_en_i && signal_i && a_nan |=> $stable(cc_o)); // R9

  AST_STAT_OTHER_BITS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start_i |=> ((stat_o & KEEP) == ($past(stat_i) & KEEP))); // R8
endmodule

bind fp_cmp_unit fp_cmp_unit_chk #(
  .EXP_W(EXP_W), .MAN_W(MAN_W), .STAT_W(STAT_W), .CC_LSB(CC_LSB)
) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .start_i(start_i), .signal_i(signal_i),
  .trap_en_i(trap_en_i), .opa_i(opa_i), .opb_i(opb_i), .stat_i(stat_i),
  .done_o(done_o), .cc_o(cc_o), .inv_o(inv_o), .stat_o(stat_o)
);

// File: tb/fp_cmp_unit_bench.sv
`timescale 1ns/1ps
module fp_cmp_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, signal_i, trap_en_i;
  logic [31:0] opa_i, opb_i, stat_i;
  logic        done_o, inv_o;
  logic [1:0]  cc_o;
  logic [31:0] stat_o;

  int total = 0;
  int bad   = 0;
  logic [1:0]  m_cc;
  logic        m_inv;
  logic [31:0] m_stat;

  always #5 clk = ~clk;

  fp_cmp_unit u_fp_cmp_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .signal_i(signal_i),
    .trap_en_i(trap_en_i), .opa_i(opa_i), .opb_i(opb_i), .stat_i(stat_i),
    .done_o(done_o), .cc_o(cc_o), .inv_o(inv_o), .stat_o(stat_o)
  );

  function automatic bit is_nan(logic [31:0] v);
    return (v[30:23] == 8'hff) && (v[22:0] != 0);
  endfunction
  function automatic bit is_snan(logic [31:0] v);
    return is_nan(v) && !v[22];
  endfunction
  function automatic logic [1:0] exp_cc(logic [31:0] a, logic [31:0] b);
    if (is_nan(a) || is_nan(b)) return 2'd3;
    if (a[30:0] == 0 && b[30:0] == 0) return 2'd0;
    if (a == b) return 2'd0;
    if (a[31] != b[31]) return a[31] ? 2'd1 : 2'd2;
    if (a[31] == 1'b0) return (a[30:0] < b[30:0]) ? 2'd1 : 2'd2;
    return (a[30:0] > b[30:0]) ? 2'd1 : 2'd2;
  endfunction
  function automatic bit exp_inv(logic [31:0] a, logic [31:0] b, bit sig);
    if (exp_cc(a, b) != 2'd3) return 1'b0;
    return sig || is_snan(a) || is_snan(b);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; leaves at the next negedge after checking
  task automatic do_op(logic [31:0] a, logic [31:0] b, bit sig, bit trap,
                       string req);
    logic [1:0]  ecc;
    bit          einv;
    logic [31:0] sv;
    sv = $urandom;
    opa_i = a; opb_i = b; signal_i = sig; trap_en_i = trap; stat_i = sv;
    start_i = 1'b1;
    ecc  = exp_cc(a, b);
    einv = exp_inv(a, b, sig);
    m_inv = einv;
    if (einv && trap) begin
      m_stat = sv;                                  // R9
    end else begin
      m_cc   = ecc;
      m_stat = {sv[31:12], ecc, sv[9:0]};           // R8
    end
    @(negedge clk);
    chk(done_o == 1'b1, {"R7 done ", req}, 32'(done_o), 32'd1);
    chk(cc_o == m_cc,   {"cc ", req},      32'(cc_o),   32'(m_cc));
    chk(inv_o == m_inv, {"inv ", req},     32'(inv_o),  32'(m_inv));
    chk(stat_o == m_stat, {"R8 stat ", req}, stat_o,    m_stat);
  endtask

  task automatic idle(int n);
    start_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      stat_i = $urandom; opa_i = $urandom; opb_i = $urandom;
      @(negedge clk);
      chk(done_o == 1'b0, "R11 done low", 32'(done_o), 32'd0);
      chk(cc_o == m_cc && stat_o == m_stat && inv_o == m_inv,
          "R11 hold", stat_o, m_stat);
    end
  endtask

  function automatic logic [31:0] pick_op();
    int k = $urandom_range(0, 7);
    case (k)
      0: return {$urandom_range(0, 1) == 1, 31'd0};
      1: return {$urandom_range(0, 1) == 1, 8'hff, 23'd0};
      2: return {$urandom_range(0, 1) == 1, 8'hff, $urandom_range(0, 1) == 1,
                 22'($urandom_range(1, 4194303))};
      3: return {$urandom_range(0, 1) == 1, 8'd0, 23'($urandom)};
      4: return {$urandom_range(0, 1) == 1, 8'd127, 23'($urandom_range(0, 3))};
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] a, b;
    void'($urandom(32'd4242));
    rst_n = 1'b0; start_i = 1'b0; signal_i = 1'b0; trap_en_i = 1'b0;
    opa_i = '0; opb_i = '0; stat_i = 32'hffff_ffff;
    m_cc = 2'd0; m_inv = 1'b0; m_stat = '0;
    repeat (3) @(negedge clk);
    chk(done_o == 0 && cc_o == 0 && inv_o == 0 && stat_o == 0,
        "R10 reset state", stat_o, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(stat_o == 0 && done_o == 0, "R10 after release", stat_o, 32'd0);

    // R1 ordinary ordering
    do_op(32'h3f80_0000, 32'h4000_0000, 0, 0, "R1 1<2");
    do_op(32'h4000_0000, 32'h3f80_0000, 0, 0, "R1 2>1");
    do_op(32'hc000_0000, 32'hbf80_0000, 0, 0, "R1 -2<-1");
    do_op(32'hbf80_0000, 32'h3f80_0000, 1, 0, "R1 -1<1");
    do_op(32'h4049_0fdb, 32'h4049_0fdb, 1, 0, "R1 equal");
    // R2 zeros, denormals, infinities
    do_op(32'h0000_0000, 32'h8000_0000, 1, 1, "R2 +0=-0");
    do_op(32'h8000_0000, 32'h0000_0000, 0, 0, "R2 -0=+0");
    do_op(32'h0000_0001, 32'h8000_0000, 0, 0, "R2 denorm>-0");
    do_op(32'h8000_0002, 32'h8000_0001, 0, 0, "R2 neg denorm");
    do_op(32'h7f80_0000, 32'h7f7f_ffff, 0, 0, "R2 +inf>max");
    do_op(32'hff80_0000, 32'hff7f_ffff, 0, 0, "R2 -inf<-max");
    // R3 R5 NaN with quiet compare
    do_op(32'h7fc0_0000, 32'h3f80_0000, 0, 0, "R3 R5 qNaN quiet");
    do_op(32'h3f80_0000, 32'hff80_0001, 0, 0, "R3 R5 sNaN quiet");
    do_op(32'h7f80_0000, 32'h7f80_0000, 0, 0, "R3 inf not NaN");
    // R4 signalling compare
    do_op(32'h7fc0_0000, 32'h7fc0_0000, 1, 0, "R4 qNaN signalling");
    // R9 trap blocks commit: first an ordered result (code 1)
    do_op(32'h3f80_0000, 32'h4000_0000, 0, 1, "R9 setup");
    do_op(32'h7fff_ffff, 32'h0000_0000, 1, 1, "R9 trap sig");
    do_op(32'h3f80_0000, 32'h7f80_0001, 0, 1, "R9 trap sNaN");
    do_op(32'h7fc0_0001, 32'h0000_0000, 0, 1, "R9 quiet no trap");
    idle(3);

    for (int n = 0; n < 400; n++) begin
      a = pick_op();
      b = ($urandom_range(0, 5) == 0) ? a ^ {$urandom_range(0, 1) == 1, 31'd0}
                                      : pick_op();
      do_op(a, b, $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0,
            "R1 R3 R6 random");
      if ($urandom_range(0, 7) == 0) idle(1);
    end
    idle(2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule